// File: doc/BRIEF.md
# Isochronous Resource Lock Registers

This block holds the four shared registers that a node acting as isochronous resource manager exposes to the bus. They are the bus-manager identity, the bandwidth still available, and the two 32-bit halves of the channel-availability bitmap. Requesters read them, and claim or return resources through compare-swap lock requests. Each register has its own lock rule. The identity register uses a plain compare-and-replace. The bandwidth register uses guarded subtraction and addition inside a 13-bit range. The channel registers use an affected-bits test that toggles only the bits in which argument and data differ.

A request is presented for one cycle. It carries an operation, a byte address inside the register window, an extended code, an argument and a data value. One cycle later the block returns a response code and a value. For a successful lock the value is the argument. For a failed lock it is the current contents. A 64-bit lock spans both channel halves as one atomic operation. The broadcast channel, bit 0 of the high channel half, can never be handed back. A bus-reset input restores the register contents and does nothing else.

Top module: `irm_lock_regs`

## Requirements
- R1: On rst_n low, and in the cycle after bus_reset is sampled high, the registers hold these values: identity 0x3F, bandwidth 4915, channels high 0xFFFFFFFE, channels low 0xFFFFFFFF.
- R2: The register index is addr[3:2], mapped as 0 = identity, 1 = bandwidth, 2 = channels high, 3 = channels low. req_op encodes 0 = read, 1 = write, 2 = 32-bit lock, 3 = 64-bit lock. rsp_code encodes 0 = complete, 1 = type error, 2 = address error. A request sampled at one edge gives rsp_valid and its response at the next edge. A read returns the register in rsp_value[31:0] with code complete.
- R3: A write to any of the four registers returns a type error and changes no register.
- R4: A lock whose extended code differs from the compare-swap code (2) returns a type error and changes nothing.
- R5: An address with addr[1:0] not zero, or an index of 4 or more, returns an address error with value 0 and changes nothing.
- R6: An identity lock always returns the current value. It stores the data only when the current value equals the argument.
- R7: A bandwidth lock with an argument above 0x1FFF changes nothing and returns the current value. Otherwise only data[12:0] is used.
- R8: A bandwidth lock with argument ≥ data allocates (argument − data). If that amount is no more than the current value, the block subtracts it and returns the argument. Otherwise it changes nothing and returns the current value.
- R9: A bandwidth lock with argument < data frees (data − argument). If current + amount is below 0x2000, the block adds it and returns the argument. Otherwise it changes nothing and returns the current value.
- R10: A channel lock toggles the bits of argument XOR data when the argument matches the current value on all of those bits, and returns the argument. Otherwise it returns the current value unchanged.
- R11: Data bit 0 of the high half (bit 32 of a 64-bit lock) is cleared before the lock, so channel-high bit 0 stays 0 at all times.
- R12: A 64-bit lock is accepted only at address 8 and returns {high, low}. At any other in-range index it returns a type error.
- R13: Requests on consecutive cycles are applied in order, and each one sees the result of the previous one.
- R14: A request in a cycle with bus_reset high still gets its response from the old contents. Its update is discarded in favour of the restored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Restores the register contents |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: read, write, lock32, lock64 |
| req_addr | input | ADDR_W | Byte address inside the register window |
| req_ext | input | EXT_W | Extended lock code |
| req_arg | input | 64 | Lock argument (32-bit locks use bits 31:0) |
| req_data | input | 64 | Lock data or write data |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Response code |
| rsp_value | output | 64 | Old or result value |

## Verification
The bench builds the block with its default parameters. With ADDR_W = 6 the index field runs to 15, so out-of-range indices sit next to the four live registers and the address-error path can be reached. With a 13-bit bandwidth field, a single free of 0x1FFF from an empty pool lands exactly on the ceiling, and the next one-unit free tests the strict upper bound. The channel tests drive the broadcast channel through release attempts by both 32-bit and 64-bit locks, mixed with real claims on other bits.

// File: rtl/irm_pkg.sv
package irm_pkg;
    localparam int REG_W = 32;
    localparam int VAL_W = 2 * REG_W;
    localparam int NUM_REGS = 4;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_LOCK32 = 2'd2,
        OP_LOCK64 = 2'd3
    } irm_op_e;

    typedef enum logic [1:0] {
        RSP_COMPLETE = 2'd0,
        RSP_TYPE_ERR = 2'd1,
        RSP_ADDR_ERR = 2'd2
    } irm_rsp_e;

    typedef struct packed {
        logic [REG_W-1:0] bm;
        logic [REG_W-1:0] bw;
        logic [REG_W-1:0] ch_hi;
        logic [REG_W-1:0] ch_lo;
    } irm_regs_t;

    typedef struct packed {
        irm_regs_t        regs;
        logic             rsp_valid;
        logic [1:0]       rsp_code;
        logic [VAL_W-1:0] rsp_value;
    } irm_state_t;
endpackage

// File: rtl/irm_req_decode.sv
module irm_req_decode
    import irm_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int EXT_W    = 4,
    parameter int CAS_CODE = 2
) (
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [EXT_W-1:0]  ext,
    output logic [1:0]        code,
    output logic [1:0]        sel,
    output logic              is_read,
    output logic              is_lock32,
    output logic              is_lock64
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [1:0] CH_HI_IDX = 2'd2;

    logic [IDX_W-1:0] idx;
    logic             misaligned;
    logic             in_range;
    logic             cas;

    assign idx        = addr[ADDR_W-1:2];
    assign misaligned = |addr[1:0];
    assign in_range   = idx < IDX_W'(NUM_REGS);
    assign cas        = ext == EXT_W'(CAS_CODE);
    assign sel        = idx[1:0];

    always_comb begin
        code      = RSP_COMPLETE;
        is_read   = 1'b0;
        is_lock32 = 1'b0;
        is_lock64 = 1'b0;
        if (misaligned || !in_range) begin
            code = RSP_ADDR_ERR;
        end else begin
            case (op)
                OP_READ:  is_read = 1'b1;
                OP_WRITE: code = RSP_TYPE_ERR;
                OP_LOCK32: begin
                    if (cas) is_lock32 = 1'b1;
                    else     code = RSP_TYPE_ERR;
                end
                default: begin
                    if (cas && sel == CH_HI_IDX) is_lock64 = 1'b1;
                    else                         code = RSP_TYPE_ERR;
                end
            endcase
        end
    end
endmodule

// File: rtl/irm_bw_cas.sv
module irm_bw_cas
    import irm_pkg::*;
#(
    parameter int BW_W = 13
) (
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] arg,
    input  logic [REG_W-1:0] data,
    output logic             upd,
    output logic [REG_W-1:0] new_val,
    output logic [REG_W-1:0] ret
);
    localparam logic [REG_W:0] LIMIT = (REG_W + 1)'(1) << BW_W;

    logic             arg_over;
    logic [REG_W-1:0] data_m;
    logic [REG_W:0]   amt;
    logic [REG_W:0]   sum;

    assign arg_over = |arg[REG_W-1:BW_W];
    assign data_m   = {{(REG_W - BW_W){1'b0}}, data[BW_W-1:0]};

    always_comb begin
        upd     = 1'b0;
        new_val = cur;
        ret     = cur;
        amt     = '0;
        sum     = '0;
        if (!arg_over) begin
            if (arg >= data_m) begin
                amt = {1'b0, arg} - {1'b0, data_m};
                if ({1'b0, cur} >= amt) begin
                    upd     = 1'b1;
                    new_val = cur - amt[REG_W-1:0];
                    ret     = arg;
                end
            end else begin
                amt = {1'b0, data_m} - {1'b0, arg};
                sum = {1'b0, cur} + amt;
                if (sum < LIMIT) begin
                    upd     = 1'b1;
                    new_val = sum[REG_W-1:0];
                    ret     = arg;
                end
            end
        end
    end
endmodule

// File: rtl/irm_chan_cas.sv
module irm_chan_cas #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] arg,
    input  logic [W-1:0] data,
    output logic         upd,
    output logic [W-1:0] new_val,
    output logic [W-1:0] ret
);
    logic [W-1:0] affected;

    assign affected = arg ^ data;
    assign upd      = ((arg ^ cur) & affected) == '0;
    assign new_val  = upd ? (cur ^ affected) : cur;
    assign ret      = upd ? arg : cur;
endmodule

// File: rtl/irm_lock_regs.sv
module irm_lock_regs
    import irm_pkg::*;
#(
    parameter int               ADDR_W   = 6,
    parameter int               EXT_W    = 4,
    parameter int               CAS_CODE = 2,
    parameter int               BW_W     = 13,
    parameter logic [REG_W-1:0] BM_INIT  = 32'h0000_003F,
    parameter logic [REG_W-1:0] BW_INIT  = 32'd4915,
    parameter logic [REG_W-1:0] CHH_INIT = 32'hFFFF_FFFE,
    parameter logic [REG_W-1:0] CHL_INIT = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [EXT_W-1:0]  req_ext,
    input  logic [63:0]       req_arg,
    input  logic [63:0]       req_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [63:0]       rsp_value
);
    localparam irm_regs_t REGS_INIT = '{bm: BM_INIT, bw: BW_INIT, ch_hi: CHH_INIT, ch_lo: CHL_INIT};
    localparam logic [REG_W-1:0] BCAST_CLR = ~(REG_W'(1));

    irm_state_t st_q, st_d;

    logic [1:0] dec_code;
    logic [1:0] dec_sel;
    logic       dec_read, dec_lock32, dec_lock64;

    irm_req_decode #(
        .ADDR_W  (ADDR_W),
        .EXT_W   (EXT_W),
        .CAS_CODE(CAS_CODE)
    ) u_decode (
        .op       (req_op),
        .addr     (req_addr),
        .ext      (req_ext),
        .code     (dec_code),
        .sel      (dec_sel),
        .is_read  (dec_read),
        .is_lock32(dec_lock32),
        .is_lock64(dec_lock64)
    );

    // operand selection
    logic [REG_W-1:0] arg32, data32, rd_word, ch_cur32, ch_data32;
    logic             sel_hi;

    assign arg32     = req_arg[REG_W-1:0];
    assign data32    = req_data[REG_W-1:0];
    assign sel_hi    = dec_sel == 2'd2;
    assign ch_cur32  = sel_hi ? st_q.regs.ch_hi : st_q.regs.ch_lo;
    assign ch_data32 = sel_hi ? (data32 & BCAST_CLR) : data32;

    always_comb begin
        case (dec_sel)
            2'd0:    rd_word = st_q.regs.bm;
            2'd1:    rd_word = st_q.regs.bw;
            2'd2:    rd_word = st_q.regs.ch_hi;
            default: rd_word = st_q.regs.ch_lo;
        endcase
    end

    // per-register lock engines
    logic             bw_upd;
    logic [REG_W-1:0] bw_new, bw_ret;

    irm_bw_cas #(.BW_W(BW_W)) u_bw (
        .cur    (st_q.regs.bw),
        .arg    (arg32),
        .data   (data32),
        .upd    (bw_upd),
        .new_val(bw_new),
        .ret    (bw_ret)
    );

    logic             ch32_upd;
    logic [REG_W-1:0] ch32_new, ch32_ret;

    irm_chan_cas #(.W(REG_W)) u_ch32 (
        .cur    (ch_cur32),
        .arg    (arg32),
        .data   (ch_data32),
        .upd    (ch32_upd),
        .new_val(ch32_new),
        .ret    (ch32_ret)
    );

    logic             ch64_upd;
    logic [VAL_W-1:0] ch64_new, ch64_ret, ch64_data;

    assign ch64_data = {req_data[VAL_W-1:REG_W] & BCAST_CLR, req_data[REG_W-1:0]};

    irm_chan_cas #(.W(VAL_W)) u_ch64 (
        .cur    ({st_q.regs.ch_hi, st_q.regs.ch_lo}),
        .arg    (req_arg),
        .data   (ch64_data),
        .upd    (ch64_upd),
        .new_val(ch64_new),
        .ret    (ch64_ret)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_code  = RSP_COMPLETE;
        st_d.rsp_value = '0;
        if (req_valid) begin
            st_d.rsp_code = dec_code;
            if (dec_read) begin
                st_d.rsp_value = {{REG_W{1'b0}}, rd_word};
            end
            if (dec_lock32) begin
                case (dec_sel)
                    2'd0: begin
                        st_d.rsp_value = {{REG_W{1'b0}}, st_q.regs.bm};
                        if (st_q.regs.bm == arg32) st_d.regs.bm = data32;
                    end
                    2'd1: begin
                        st_d.rsp_value = {{REG_W{1'b0}}, bw_ret};
                        if (bw_upd) st_d.regs.bw = bw_new;
                    end
                    default: begin
                        st_d.rsp_value = {{REG_W{1'b0}}, ch32_ret};
                        if (ch32_upd) begin
                            if (sel_hi) st_d.regs.ch_hi = ch32_new;
                            else        st_d.regs.ch_lo = ch32_new;
                        end
                    end
                endcase
            end
            if (dec_lock64) begin
                st_d.rsp_value = ch64_ret;
                if (ch64_upd) begin
                    st_d.regs.ch_hi = ch64_new[VAL_W-1:REG_W] & BCAST_CLR;
                    st_d.regs.ch_lo = ch64_new[REG_W-1:0];
                end
            end
        end
        if (bus_reset) begin
            st_d.regs = REGS_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs      <= REGS_INIT;
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_code  <= RSP_COMPLETE;
            st_q.rsp_value <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_code  = st_q.rsp_code;
    assign rsp_value = st_q.rsp_value;
endmodule

// File: rtl/irm_lock_regs_chk.sv
module irm_lock_regs_chk
    import irm_pkg::*;
#(
    parameter int               ADDR_W   = 6,
    parameter int               EXT_W    = 4,
    parameter int               CAS_CODE = 2,
    parameter int               BW_W     = 13,
    parameter logic [REG_W-1:0] BM_INIT  = 32'h0000_003F,
    parameter logic [REG_W-1:0] BW_INIT  = 32'd4915,
    parameter logic [REG_W-1:0] CHH_INIT = 32'hFFFF_FFFE,
    parameter logic [REG_W-1:0] CHL_INIT = 32'hFFFF_FFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_reset,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [EXT_W-1:0]  req_ext,
    input logic [63:0]       req_arg,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic [63:0]       rsp_value,
    input irm_regs_t         regs
);
    a_r1_bus_reset_restore: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (regs.bm == BM_INIT && regs.bw == BW_INIT &&
                       regs.ch_hi == CHH_INIT && regs.ch_lo == CHL_INIT));

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_write_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_WRITE && req_addr[1:0] == 2'b00 &&
         req_addr < ADDR_W'(16) && !bus_reset)
        |=> (rsp_code == RSP_TYPE_ERR && $stable(regs)));

    a_r5_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00 && !bus_reset)
        |=> (rsp_code == RSP_ADDR_ERR && $stable(regs)));

    a_r6_bm_mismatch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_LOCK32 && req_addr == ADDR_W'(0) &&
         req_ext == EXT_W'(CAS_CODE) && req_arg[31:0] != regs.bm && !bus_reset)
        |=> ($stable(regs.bm) && rsp_value == {32'h0, $past(regs.bm)}));

    a_r7_bw_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        regs.bw < (REG_W'(1) << BW_W));

    a_r11_bcast_held: assert property (@(posedge clk) disable iff (!rst_n)
        regs.ch_hi[0] == 1'b0);
endmodule

bind irm_lock_regs irm_lock_regs_chk #(
    .ADDR_W  (ADDR_W),
    .EXT_W   (EXT_W),
    .CAS_CODE(CAS_CODE),
    .BW_W    (BW_W),
    .BM_INIT (BM_INIT),
    .BW_INIT (BW_INIT),
    .CHH_INIT(CHH_INIT),
    .CHL_INIT(CHL_INIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_reset(bus_reset),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_addr (req_addr),
    .req_ext  (req_ext),
    .req_arg  (req_arg),
    .rsp_valid(rsp_valid),
    .rsp_code (rsp_code),
    .rsp_value(rsp_value),
    .regs     (st_q.regs)
);

// File: tb/irm_lock_regs_test.sv
`timescale 1ns/1ps
module irm_lock_regs_test;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, L32 = 2'd2, L64 = 2'd3;
    localparam logic [1:0] OK = 2'd0, TERR = 2'd1, AERR = 2'd2;
    localparam logic [3:0] CAS = 4'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [5:0]  req_addr = '0;
    logic [3:0]  req_ext = '0;
    logic [63:0] req_arg = '0;
    logic [63:0] req_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [63:0] rsp_value;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irm_lock_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_ext(req_ext), .req_arg(req_arg), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_value(rsp_value)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [5:0] addr, input logic [3:0] ext,
                         input logic [63:0] arg, input logic [63:0] data);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_ext   = ext;
        req_arg   = arg;
        req_data  = data;
    endtask

    task automatic op_chk(input string tag, input logic [1:0] op, input logic [5:0] addr,
                          input logic [3:0] ext, input logic [63:0] arg, input logic [63:0] data,
                          input logic [1:0] exp_code, input logic [63:0] exp_val);
        @(negedge clk);
        drive(op, addr, ext, arg, data);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " code"}, 64'(rsp_code), 64'(exp_code));
        check({tag, " value"}, rsp_value, exp_val);
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] addr, input logic [31:0] exp);
        op_chk(tag, RD, addr, 4'd0, 64'd0, 64'd0, OK, {32'd0, exp});
    endtask

    task automatic t_reset;
        check("R2 idle rsp_valid after reset", 64'(rsp_valid), 64'd0);
        rd_chk("R1 R2 reset bm", 6'd0, 32'h3F);
        rd_chk("R1 reset bw", 6'd4, 32'd4915);
        rd_chk("R1 reset ch_hi", 6'd8, 32'hFFFF_FFFE);
        rd_chk("R1 reset ch_lo", 6'd12, 32'hFFFF_FFFF);
    endtask

    task automatic t_bm;
        op_chk("R6 bm match", L32, 6'd0, CAS, 64'h3F, 64'h05, OK, 64'h3F);
        rd_chk("R6 bm updated", 6'd0, 32'h05);
        op_chk("R6 bm mismatch", L32, 6'd0, CAS, 64'h3F, 64'h07, OK, 64'h05);
        rd_chk("R6 bm kept", 6'd0, 32'h05);
    endtask

    task automatic t_bw;
        op_chk("R8 alloc 100", L32, 6'd4, CAS, 64'd4915, 64'd4815, OK, 64'd4915);
        rd_chk("R8 bw 4815", 6'd4, 32'd4815);
        op_chk("R8 alloc all", L32, 6'd4, CAS, 64'd4815, 64'd0, OK, 64'd4815);
        rd_chk("R8 bw empty", 6'd4, 32'd0);
        op_chk("R8 alloc too much", L32, 6'd4, CAS, 64'd10, 64'd5, OK, 64'd0);
        rd_chk("R8 bw still empty", 6'd4, 32'd0);
        op_chk("R9 free to ceiling", L32, 6'd4, CAS, 64'd0, 64'h1FFF, OK, 64'd0);
        rd_chk("R9 bw 0x1FFF", 6'd4, 32'h1FFF);
        op_chk("R9 free past ceiling", L32, 6'd4, CAS, 64'd0, 64'd1, OK, 64'h1FFF);
        rd_chk("R9 bw kept", 6'd4, 32'h1FFF);
        op_chk("R7 arg over range", L32, 6'd4, CAS, 64'h2000, 64'd0, OK, 64'h1FFF);
        op_chk("R7 data masked", L32, 6'd4, CAS, 64'h1FFF, 64'hFFFF_FFFF, OK, 64'h1FFF);
        rd_chk("R7 bw unchanged", 6'd4, 32'h1FFF);
    endtask

    task automatic t_chan;
        op_chk("R10 claim ch bit5", L32, 6'd12, CAS, 64'hFFFF_FFFF, 64'hFFFF_FFDF, OK, 64'hFFFF_FFFF);
        rd_chk("R10 lo after claim", 6'd12, 32'hFFFF_FFDF);
        op_chk("R10 stale claim", L32, 6'd12, CAS, 64'hFFFF_FFFF, 64'hFFFF_FFDF, OK, 64'hFFFF_FFDF);
        op_chk("R10 release bit5", L32, 6'd12, CAS, 64'h0, 64'h20, OK, 64'h0);
        rd_chk("R10 lo restored", 6'd12, 32'hFFFF_FFFF);
    endtask

    task automatic t_bcast;
        op_chk("R11 release ch31", L32, 6'd8, CAS, 64'hFFFF_FFFE, 64'hFFFF_FFFF, OK, 64'hFFFF_FFFE);
        rd_chk("R11 hi unchanged", 6'd8, 32'hFFFF_FFFE);
        op_chk("R11 claim bit1 + release", L32, 6'd8, CAS, 64'hFFFF_FFFE, 64'hFFFF_FFFD, OK, 64'hFFFF_FFFE);
        rd_chk("R11 hi bit1 taken bit0 kept", 6'd8, 32'hFFFF_FFFC);
    endtask

    task automatic t_lock64;
        op_chk("R12 lock64 ok", L64, 6'd8, CAS, 64'hFFFF_FFFC_FFFF_FFFF,
               64'hFFFF_FFFD_FFFF_FFF0, OK, 64'hFFFF_FFFC_FFFF_FFFF);
        rd_chk("R12 hi after lock64", 6'd8, 32'hFFFF_FFFC);
        rd_chk("R12 lo after lock64", 6'd12, 32'hFFFF_FFF0);
        op_chk("R12 lock64 stale", L64, 6'd8, CAS, 64'hFFFF_FFFC_FFFF_FFFF,
               64'hFFFF_FFFC_FFFF_FFF0, OK, 64'hFFFF_FFFC_FFFF_FFF0);
        op_chk("R12 lock64 at lo", L64, 6'd12, CAS, 64'h0, 64'h0, TERR, 64'h0);
        op_chk("R12 lock64 at bm", L64, 6'd0, CAS, 64'h5, 64'h9, TERR, 64'h0);
        rd_chk("R12 bm untouched", 6'd0, 32'h05);
    endtask

    task automatic t_errors;
        op_chk("R3 write bw", WR, 6'd4, 4'd0, 64'h0, 64'h10, TERR, 64'h0);
        rd_chk("R3 bw kept", 6'd4, 32'h1FFF);
        op_chk("R3 write ch_lo", WR, 6'd12, 4'd0, 64'h0, 64'h0, TERR, 64'h0);
        rd_chk("R3 lo kept", 6'd12, 32'hFFFF_FFF0);
        op_chk("R4 bad ext", L32, 6'd0, 4'd1, 64'h5, 64'h9, TERR, 64'h0);
        rd_chk("R4 bm kept", 6'd0, 32'h05);
        op_chk("R5 misaligned read", RD, 6'd5, 4'd0, 64'h0, 64'h0, AERR, 64'h0);
        op_chk("R5 index 4 read", RD, 6'd16, 4'd0, 64'h0, 64'h0, AERR, 64'h0);
        op_chk("R5 misaligned lock", L32, 6'd2, CAS, 64'h5, 64'h9, AERR, 64'h0);
        op_chk("R5 index 15 lock", L32, 6'd60, CAS, 64'h5, 64'h9, AERR, 64'h0);
        rd_chk("R5 bm kept", 6'd0, 32'h05);
    endtask

    task automatic t_b2b;
        @(negedge clk);
        drive(L32, 6'd0, CAS, 64'h5, 64'h9);
        @(negedge clk);
        check("R13 first ret", rsp_value, 64'h5);
        drive(L32, 6'd0, CAS, 64'h9, 64'h11);
        @(negedge clk);
        req_valid = 1'b0;
        check("R13 second sees first", rsp_value, 64'h9);
        rd_chk("R13 bm final", 6'd0, 32'h11);
    endtask

    task automatic t_busreset;
        @(negedge clk);
        drive(L32, 6'd0, CAS, 64'h11, 64'h22);
        bus_reset = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        bus_reset = 1'b0;
        check("R14 code", 64'(rsp_code), 64'(OK));
        check("R14 old value", rsp_value, 64'h11);
        rd_chk("R14 R1 bm restored", 6'd0, 32'h3F);
        rd_chk("R1 bw restored", 6'd4, 32'd4915);
        rd_chk("R1 hi restored", 6'd8, 32'hFFFF_FFFE);
        rd_chk("R1 lo restored", 6'd12, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bm();
        t_bw();
        t_chan();
        t_bcast();
        t_lock64();
        t_errors();
        t_b2b();
        t_busreset();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule